// File: doc/BRIEF.md
# Stacked Layer-2 Header Parser

This block watches a received Ethernet frame one byte per accepted beat and walks the chain of layer-2 headers that follow the two MAC addresses. At each step it reads one type field and checks it against a fixed table that says which header may follow the current one. It then skips that header's body and moves on. The walk ends at the last supported header, at the first unsupported or out-of-order type field, or at the end of the frame.

On that byte the block latches three results and pulses `done_o` for one cycle:
- the kind of the last recognised header,
- the byte offset of the first byte after the last field it read, which is where the layer-3 header starts,
- a flag for every header kind it passed through.

A layer-3 stage consumes these results. Bytes after the end of the walk are ignored until the next frame start.

Top module: `l2_stack_parser`

## Requirements
- R1: A frame starts on a beat with `valid_i` and `start_i` high; that byte has offset 0. The first type field sits at offsets 12-13. The kind is encoded NONE=0, LLC/SNAP=1, jumbo=2, VLAN=3, MPLS unicast=4, MPLS multicast=5, PPPoE session=6, ARP=7, IPv4=8, IPv6=9. NONE means no header was recognised.
- R2: Type field codes are decoded as follows:
  - 0x8100 VLAN, 0x8847 MPLS unicast, 0x8848 MPLS multicast
  - 0x8864 PPPoE session, 0x0806 ARP, 0x0800 IPv4, 0x86DD IPv6, 0x8870 jumbo
  - any value below 0x0600 is a length field that announces LLC/SNAP
  - every other value is unsupported.
- R3: Which header may follow which:
  - Plain Ethernet (NONE) may be followed by any kind.
  - VLAN may be followed by any kind except jumbo.
  - LLC/SNAP may be followed only by MPLS unicast, MPLS multicast, ARP, IPv4 or IPv6.
  - ARP, IPv4 and IPv6 end the walk.
- R4: An unsupported type, or one not allowed after the current header, ends the walk without error. The reported kind stays that of the last accepted header. The offset points just past the rejected type field.
- R5: A VLAN tag is a 2-byte tag control field followed by the next type field. LLC/SNAP is 8 bytes:
  - bytes 0-2 must be AA, AA, 03, and any mismatch ends the walk with the kind unchanged;
  - bytes 6-7 are the next type field.
  Each completed type field, SNAP header or MPLS label moves the reported offset to the byte after it.
- R6: MPLS labels are 4 bytes each. The walk continues label by label until a label has bit 0 of its third byte set. The top nibble of the byte after that label then selects IPv4 (4) or IPv6 (6); any other nibble leaves the MPLS kind. The offset stays at the byte after the last label.
- R7: A PPPoE session header is 8 bytes; its last two bytes are a PPP protocol number. 0x0021 selects IPv4, 0x0057 selects IPv6, and any other value leaves the PPPoE kind. The offset is the byte after the 8 bytes.
- R8: A jumbo type field must be followed directly by a SNAP header with no length field. After that SNAP header passes, the kind becomes LLC/SNAP and its type field is judged as coming after LLC/SNAP.
- R9: `seen_o` bit (kind-1) is set for every kind the walk accepted. LLC/SNAP is counted only after its AA-AA-03 check passes. When the kind is NONE, all flags are clear.
- R10: The results are registered. `done_o` is high for exactly one cycle, the cycle after the byte that ends the walk, and only once per frame. The outputs hold their values between pulses.
- R11: A frame whose last byte (`last_i`) arrives before the walk ends reports with `trunc_o`=1. It keeps the kind, offset and flags reached so far. A walk that ends on the last byte itself is not truncated.
- R12: If `depth_i` is 0 on the start byte, the walk is skipped. The result is issued right after the start byte with kind NONE, offset 0, no flags and no truncation.
- R13: A start byte in the middle of an unfinished walk discards that walk and begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the first byte of a frame |
| valid_i | input | 1 | Byte on data_i is valid |
| last_i | input | 1 | Marks the last byte of a frame |
| data_i | input | 8 | Frame byte |
| depth_i | input | 2 | Parse depth; 0 disables the walk |
| done_o | output | 1 | One-cycle result pulse |
| kind_o | output | 4 | Last recognised header kind |
| l3_off_o | output | OFF_W | Offset of the layer-3 header |
| seen_o | output | 9 | Flags of header kinds passed |
| trunc_o | output | 1 | Frame ended before the walk finished |

## Verification
The situations that are hardest to reach from the ports combine two or three headers: a rejected succession deep in a stack, an MPLS peek byte that the next header's type field supplies, and a SNAP header behind a jumbo type. The bench concatenates every ordered triple from a set of thirteen header fragments, including a broken SNAP, an unknown type and a two-label MPLS stack, and compares each result with an arithmetic walk over the same bytes. It also checks the cycle of the result pulse. Selected stacks are then cut at every possible length to reach each truncation point, and idle beats are interleaved throughout.

// File: rtl/l2hp_pkg.sv
package l2hp_pkg;
  localparam int unsigned NKIND = 9;

  typedef enum logic [3:0] {
    K_NONE = 4'd0, K_LLC = 4'd1, K_JUMBO = 4'd2, K_VLAN = 4'd3, K_MPLSU = 4'd4,
    K_MPLSM = 4'd5, K_PPPOE = 4'd6, K_ARP = 4'd7, K_IPV4 = 4'd8, K_IPV6 = 4'd9
  } l2_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MAC, ST_TYPE, ST_TCI, ST_SNAP, ST_LBL, ST_PEEK, ST_PPP
  } walk_st_e;

  localparam logic [15:0] ET_LEN_LIM = 16'h0600;
  localparam logic [15:0] ET_VLAN    = 16'h8100;
  localparam logic [15:0] ET_MPLSU   = 16'h8847;
  localparam logic [15:0] ET_MPLSM   = 16'h8848;
  localparam logic [15:0] ET_PPPOE   = 16'h8864;
  localparam logic [15:0] ET_ARP     = 16'h0806;
  localparam logic [15:0] ET_IPV4    = 16'h0800;
  localparam logic [15:0] ET_IPV6    = 16'h86DD;
  localparam logic [15:0] ET_JUMBO   = 16'h8870;
  localparam logic [15:0] PPP_IPV4   = 16'h0021;
  localparam logic [15:0] PPP_IPV6   = 16'h0057;

  function automatic logic [NKIND-1:0] kind_bit(l2_kind_e k);
    if (k == K_NONE) return '0;
    return {{(NKIND-1){1'b0}}, 1'b1} << (k - 4'd1);
  endfunction
endpackage

// File: rtl/l2hp_pos_ctr.sv
module l2hp_pos_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         valid_i,
  output logic [W-1:0] pos_o
);
  logic [W-1:0] cnt_q;

  assign pos_o = start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= (pos_o == '1) ? pos_o : pos_o + 1'b1;
  end
endmodule

// File: rtl/l2hp_type_decode.sv
module l2hp_type_decode
  import l2hp_pkg::*;
(
  input  logic [15:0] et_i,
  input  l2_kind_e    cur_i,
  output l2_kind_e    kind_o,
  output logic        legal_o
);
  logic [9:0] allow;

  always_comb begin
    if (et_i < ET_LEN_LIM) kind_o = K_LLC;
    else begin
      case (et_i)
        ET_VLAN:  kind_o = K_VLAN;
        ET_MPLSU: kind_o = K_MPLSU;
        ET_MPLSM: kind_o = K_MPLSM;
        ET_PPPOE: kind_o = K_PPPOE;
        ET_ARP:   kind_o = K_ARP;
        ET_IPV4:  kind_o = K_IPV4;
        ET_IPV6:  kind_o = K_IPV6;
        ET_JUMBO: kind_o = K_JUMBO;
        default:  kind_o = K_NONE;
      endcase
    end
  end

  // succession table: bit n allows kind n after cur_i
  always_comb begin
    case (cur_i)
      K_NONE:  allow = 10'b11_1111_1110;
      K_VLAN:  allow = 10'b11_1111_1010;
      K_LLC:   allow = 10'b11_1011_0000;
      default: allow = 10'b00_0000_0000;
    endcase
  end

  assign legal_o = allow[kind_o];
endmodule

// File: rtl/l2_stack_parser.sv
module l2_stack_parser
  import l2hp_pkg::*;
#(
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned MAC_BYTES = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [7:0]       data_i,
  input  logic [1:0]       depth_i,
  output logic             done_o,
  output logic [3:0]       kind_o,
  output logic [OFF_W-1:0] l3_off_o,
  output logic [NKIND-1:0] seen_o,
  output logic             trunc_o
);
  localparam logic [OFF_W-1:0] MAC_END = OFF_W'(MAC_BYTES - 1);
  localparam logic [OFF_W-1:0] TYPE_AT = OFF_W'(MAC_BYTES);

  walk_st_e         st_q, n_st, b_st;
  logic [2:0]       sub_q, n_sub, b_sub;
  logic [7:0]       hi_q;
  logic             bos_q, n_bos;
  l2_kind_e         cur_q, n_cur, b_cur, d_cur, dk;
  logic [OFF_W-1:0] off_q, n_off, b_off, pos, pos_nxt;
  logic [NKIND-1:0] seen_q, n_seen, b_seen;
  logic             fin, trunc, do_disp, d_legal;

  l2_kind_e         res_kind;
  logic [OFF_W-1:0] res_off;
  logic [NKIND-1:0] res_seen;
  logic             res_trunc, done_q;

  l2hp_pos_ctr #(.W(OFF_W)) u_pos (
    .clk_i, .rst_ni, .start_i, .valid_i, .pos_o(pos)
  );

  assign pos_nxt = (pos == '1) ? pos : pos + 1'b1;
  assign b_st    = start_i ? ST_MAC : st_q;
  assign b_sub   = start_i ? 3'd0 : sub_q;
  assign b_cur   = start_i ? K_NONE : cur_q;
  assign b_off   = start_i ? TYPE_AT : off_q;
  assign b_seen  = start_i ? '0 : seen_q;
  // after a SNAP header the inner type is judged as following LLC/SNAP
  assign d_cur   = (b_st == ST_SNAP) ? K_LLC : b_cur;

  l2hp_type_decode u_dec (
    .et_i({hi_q, data_i}), .cur_i(d_cur), .kind_o(dk), .legal_o(d_legal)
  );

  always_comb begin
    n_st = st_q; n_sub = sub_q; n_bos = bos_q; n_cur = cur_q;
    n_off = off_q; n_seen = seen_q;
    fin = 1'b0; trunc = 1'b0; do_disp = 1'b0;
    if (valid_i) begin
      n_st = b_st; n_cur = b_cur; n_off = b_off; n_seen = b_seen;
      n_sub = b_sub + 3'd1;
      if (start_i && depth_i == 2'd0) begin
        fin = 1'b1;
        n_off = '0;
      end else begin
        case (b_st)
          ST_MAC: if (pos == MAC_END) begin n_st = ST_TYPE; n_sub = '0; end
          ST_TYPE: if (b_sub[0]) begin n_off = pos_nxt; do_disp = 1'b1; end
          ST_TCI: if (b_sub[0]) begin n_st = ST_TYPE; n_sub = '0; end
          ST_SNAP: begin
            case (b_sub)
              3'd0, 3'd1: if (data_i != 8'hAA) fin = 1'b1;
              3'd2:       if (data_i != 8'h03) fin = 1'b1;
              3'd7: begin
                n_cur = K_LLC;
                n_seen = n_seen | kind_bit(K_LLC);
                n_off = pos_nxt;
                do_disp = 1'b1;
              end
              default: ;
            endcase
          end
          ST_LBL: begin
            if (b_sub == 3'd2) n_bos = data_i[0];
            if (b_sub == 3'd3) begin
              n_off = pos_nxt;
              n_sub = '0;
              if (bos_q) n_st = ST_PEEK;
            end
          end
          ST_PEEK: begin
            fin = 1'b1;
            if (data_i[7:4] == 4'd4) begin n_cur = K_IPV4; n_seen = n_seen | kind_bit(K_IPV4); end
            if (data_i[7:4] == 4'd6) begin n_cur = K_IPV6; n_seen = n_seen | kind_bit(K_IPV6); end
          end
          ST_PPP: if (b_sub == 3'd7) begin
            n_off = pos_nxt;
            fin = 1'b1;
            if ({hi_q, data_i} == PPP_IPV4) begin n_cur = K_IPV4; n_seen = n_seen | kind_bit(K_IPV4); end
            if ({hi_q, data_i} == PPP_IPV6) begin n_cur = K_IPV6; n_seen = n_seen | kind_bit(K_IPV6); end
          end
          default: ;
        endcase

        if (do_disp) begin
          n_sub = '0;
          if (dk == K_NONE || !d_legal) fin = 1'b1;
          else begin
            if (dk != K_LLC) begin
              n_cur = dk;
              n_seen = n_seen | kind_bit(dk);
            end
            case (dk)
              K_LLC, K_JUMBO:   n_st = ST_SNAP;
              K_VLAN:           n_st = ST_TCI;
              K_MPLSU, K_MPLSM: n_st = ST_LBL;
              K_PPPOE:          n_st = ST_PPP;
              default:          fin = 1'b1;
            endcase
          end
        end

        if (!fin && last_i && b_st != ST_IDLE) begin
          fin = 1'b1;
          trunc = 1'b1;
        end
      end
      if (fin) n_st = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sub_q <= '0; hi_q <= '0; bos_q <= 1'b0;
      cur_q <= K_NONE; off_q <= '0; seen_q <= '0;
    end else begin
      st_q <= n_st; sub_q <= n_sub; bos_q <= n_bos;
      cur_q <= n_cur; off_q <= n_off; seen_q <= n_seen;
      if (valid_i) hi_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0; res_kind <= K_NONE; res_off <= '0;
      res_seen <= '0; res_trunc <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        res_kind <= n_cur; res_off <= n_off;
        res_seen <= n_seen; res_trunc <= trunc;
      end
    end
  end

  assign done_o   = done_q;
  assign kind_o   = res_kind;
  assign l3_off_o = res_off;
  assign seen_o   = res_seen;
  assign trunc_o  = res_trunc;
endmodule

// File: rtl/l2_stack_parser_chk.sv
module l2_stack_parser_chk #(
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned MAC_BYTES = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             valid_i,
  input logic [1:0]       depth_i,
  input logic             done_o,
  input logic [3:0]       kind_o,
  input logic [OFF_W-1:0] l3_off_o,
  input logic [8:0]       seen_o,
  input logic             trunc_o
);
  p_done_follows_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));

  p_result_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(kind_o) && $stable(l3_off_o) && $stable(seen_o) && $stable(trunc_o)));

  p_kind_flagged_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && kind_o != 4'd0) |-> seen_o[kind_o - 4'd1]);

  p_none_no_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && kind_o == 4'd0) |-> (seen_o == '0));

  p_depth_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && depth_i == 2'd0) |=> (done_o && kind_o == 4'd0 && l3_off_o == '0 && !trunc_o));

  p_off_past_mac_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trunc_o && kind_o != 4'd0) |-> (l3_off_o >= OFF_W'(MAC_BYTES + 2)));
endmodule

bind l2_stack_parser l2_stack_parser_chk #(.OFF_W(OFF_W), .MAC_BYTES(MAC_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i), .depth_i(depth_i),
  .done_o(done_o), .kind_o(kind_o), .l3_off_o(l3_off_o), .seen_o(seen_o), .trunc_o(trunc_o)
);

// File: tb/l2_stack_parser_test.sv
module l2_stack_parser_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [1:0] depth_i = 2'd1;
  logic       done_o, trunc_o;
  logic [3:0] kind_o;
  logic [7:0] l3_off_o;
  logic [8:0] seen_o;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, gctr = 0;
  int d_cnt = 0, d_cyc = 0;
  logic [3:0] c_kind; logic [7:0] c_off; logic [8:0] c_seen; logic c_trunc;
  logic [7:0] frm [0:63];
  int dcy [0:63];
  int flen = 0;
  int cb = 0;

  l2_stack_parser uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i), .last_i(last_i),
    .data_i(data_i), .depth_i(depth_i), .done_o(done_o), .kind_o(kind_o),
    .l3_off_o(l3_off_o), .seen_o(seen_o), .trunc_o(trunc_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (done_o) begin
    d_cnt++; d_cyc = cyc;
    c_kind = kind_o; c_off = l3_off_o; c_seen = seen_o; c_trunc = trunc_o;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void put(input logic [7:0] b);
    frm[flen] = b; flen++;
  endfunction

  // header fragments: type field plus body, the next fragment supplies the inner type
  function automatic void emit(input int c);
    case (c)
      0: begin put(8'h81); put(8'h00); put(8'h00); put(8'h05); end
      1: begin put(8'h88); put(8'h47); put(8'h00); put(8'h01); put(8'h41); put(8'h40); end
      2: begin put(8'h88); put(8'h48); put(8'h00); put(8'h02); put(8'h00); put(8'h40);
               put(8'h00); put(8'h03); put(8'h01); put(8'h40); end
      3, 4, 5: begin put(8'h88); put(8'h64); put(8'h11); put(8'h00); put(8'h00); put(8'h01);
               put(8'h00); put(8'h20);
               if (c == 3) begin put(8'h00); put(8'h21); end
               else if (c == 4) begin put(8'h00); put(8'h57); end
               else begin put(8'hC0); put(8'h21); end end
      6: begin put(8'h08); put(8'h06); end
      7: begin put(8'h08); put(8'h00); end
      8: begin put(8'h86); put(8'hDD); end
      9, 10, 11: begin
           if (c == 11) begin put(8'h88); put(8'h70); end
           else begin put(8'h00); put(8'h40); end
           put(8'hAA); put(c == 10 ? 8'hAB : 8'hAA); put(8'h03);
           put(8'h00); put(8'h00); put(8'h00); end
      default: begin put(8'h12); put(8'h34); end
    endcase
  endfunction

  function automatic void build(input int a, input int b, input int c, input logic [7:0] pay);
    flen = 0;
    for (int i = 0; i < 12; i++) put(8'(8'h10 + i));
    if (a >= 0) emit(a);
    if (b >= 0) emit(b);
    if (c >= 0) emit(c);
    put(pay); put(8'h00); put(8'h11); put(8'h22);
  endfunction

  function automatic logic [7:0] rd(input int i);
    cb = i;
    return frm[i];
  endfunction

  function automatic int m_class(input int et);
    if (et < 'h600) return 1;
    case (et)
      'h8100: return 3; 'h8847: return 4; 'h8848: return 5; 'h8864: return 6;
      'h0806: return 7; 'h0800: return 8; 'h86DD: return 9; 'h8870: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_legal(input int cur, input int nk);
    if (cur == 0) return nk != 0;
    if (cur == 3) return nk != 0 && nk != 2;
    if (cur == 1) return nk == 4 || nk == 5 || nk == 7 || nk == 8 || nk == 9;
    return 0;
  endfunction

  // arithmetic walk over frm[0:n-1]; cb ends as the index of the concluding byte
  task automatic model(input int n, input int dep, output int kind, output int off,
                       output int seen, output int trn);
    int p, et, nk, pp; bit need, bos; logic [7:0] t;
    kind = 0; off = 12; seen = 0; trn = 0; cb = 0; p = 12; need = 1; et = 0;
    if (dep == 0) begin off = 0; return; end
    forever begin
      if (need) begin
        if (p + 2 > n) begin trn = 1; cb = n - 1; return; end
        et = {rd(p), rd(p + 1)}; p += 2; off = p;
      end
      need = 1;
      nk = m_class(et);
      if (nk == 0 || !m_legal(kind, nk)) return;
      if (nk == 1 || nk == 2) begin
        if (nk == 2) begin kind = 2; seen |= 2; end
        for (int j = 0; j < 3; j++) begin
          if (p + j >= n) begin trn = 1; cb = n - 1; return; end
          t = rd(p + j);
          if (t != ((j == 2) ? 8'h03 : 8'hAA)) return;
        end
        if (p + 8 > n) begin trn = 1; cb = n - 1; return; end
        et = {rd(p + 6), rd(p + 7)}; p += 8; off = p;
        kind = 1; seen |= 1; need = 0;
      end else begin
        kind = nk; seen |= 1 << (nk - 1);
        if (nk == 3) begin
          if (p + 2 > n) begin trn = 1; cb = n - 1; return; end
          p += 2;
        end else if (nk == 4 || nk == 5) begin
          bos = 0;
          while (!bos) begin
            if (p + 4 > n) begin trn = 1; cb = n - 1; return; end
            t = rd(p + 2); bos = t[0]; p += 4; off = p;
          end
          if (p >= n) begin trn = 1; cb = n - 1; return; end
          t = rd(p);
          if (t[7:4] == 4'd4) begin kind = 8; seen |= 1 << 7; end
          if (t[7:4] == 4'd6) begin kind = 9; seen |= 1 << 8; end
          return;
        end else if (nk == 6) begin
          if (p + 8 > n) begin trn = 1; cb = n - 1; return; end
          pp = {rd(p + 6), rd(p + 7)}; p += 8; off = p;
          if (pp == 'h21) begin kind = 8; seen |= 1 << 7; end
          if (pp == 'h57) begin kind = 9; seen |= 1 << 8; end
          return;
        end else return;
      end
    end
  endtask

  task automatic send(input int n, input bit st, input bit ls);
    for (int i = 0; i < n; i++) begin
      if (gctr % 7 == 3) begin
        @(negedge clk); valid_i = 1'b0; start_i = 1'b0; last_i = 1'b0;
      end
      gctr++;
      @(negedge clk);
      valid_i = 1'b1; data_i = frm[i]; start_i = (i == 0) && st; last_i = (i == n - 1) && ls;
      dcy[i] = cyc;
    end
    @(negedge clk); valid_i = 1'b0; start_i = 1'b0; last_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input int n, input int dep, input string tag);
    int ek, eo, es, et, ecb;
    model(n, dep, ek, eo, es, et);
    ecb = cb;
    depth_i = 2'(dep);
    d_cnt = 0;
    send(n, 1'b1, 1'b1);
    chk("R10", {tag, " done count"}, d_cnt, 1);
    if (d_cnt == 1) begin
      chk("R10", {tag, " done cycle"}, d_cyc, dcy[ecb] + 1);
      chk(tag, "kind", int'(c_kind), ek);
      chk(tag, "l3 offset", int'(c_off), eo);
      chk("R9", {tag, " seen"}, int'(c_seen), es);
      chk("R11", {tag, " trunc"}, int'(c_trunc), et);
    end
  endtask

  function automatic string tag_of(input int a);
    case (a)
      0, 9, 10: return "R5";
      1, 2:     return "R6";
      3, 4, 5:  return "R7";
      11:       return "R8";
      12:       return "R4";
      default:  return "R2";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset done", int'(done_o), 0);
    chk("R1", "reset kind", int'(kind_o), 0);
    chk("R10", "reset off", int'(l3_off_o), 0);
    chk("R9", "reset seen", int'(seen_o), 0);
    chk("R11", "reset trunc", int'(trunc_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: every ordered triple of fragments, successions checked against the table
    idx = 0;
    for (int a = 0; a < 13; a++)
      for (int b = 0; b < 13; b++)
        for (int c = 0; c < 13; c++) begin
          build(a, b, c, ((a + b + c) % 2 == 0) ? 8'h45 : 8'h60);
          run(flen, 1 + (idx % 3), tag_of(a));
          idx++;
        end

    // R1: untagged frame with nothing behind the MAC addresses but the payload
    build(-1, -1, -1, 8'h45);
    run(flen, 2, "R1");

    // R11: every cut point of a few stacks
    for (int s = 0; s < 3; s++) begin
      int fl;
      if (s == 0) build(0, 2, 7, 8'h45);
      else if (s == 1) build(11, 3, -1, 8'h45);
      else build(9, 0, 8, 8'h60);
      fl = flen;
      for (int n = 1; n <= fl; n++) begin
        if (s == 0) build(0, 2, 7, 8'h45);
        else if (s == 1) build(11, 3, -1, 8'h45);
        else build(9, 0, 8, 8'h60);
        run(n, 3, "R11");
      end
    end

    // R12: walk disabled by zero depth
    build(0, 7, -1, 8'h45);
    run(flen, 0, "R12");

    // R13: an unfinished walk is dropped when a new start arrives
    build(0, 7, -1, 8'h45);
    depth_i = 2'd1;
    d_cnt = 0;
    send(15, 1'b1, 1'b0);
    chk("R13", "no result for open walk", d_cnt, 0);
    build(1, -1, -1, 8'h60);
    run(flen, 1, "R13");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule